// File: doc/BRIEF.md
# Ethernet Transmit Event Interrupt Monitor

This block follows a half-duplex Ethernet MAC through each transmit attempt and turns the notable outcomes into a single interrupt line. The MAC reports the start of every attempt (and whether it is the first attempt of a new packet), the end of its preamble, the end of the attempt, collisions and carrier sense. The block counts bit times from a bit-clock enable and system clock cycles for the length limit. It recognises seven events: a clean send, a packet that saw collisions, a collision past the slot window, the retry limit being reached, an over-long transmission, no carrier once the preamble is out, and no heartbeat (SQE) collision after the attempt.

Software selects the events it wants through one 16-bit configuration register. The low six bits of that register always read back a fixed code that identifies it. When the block sees a late collision, the retry limit or an over-long transmission, it tells the MAC to abandon the attempt. On a late collision it also tells the MAC to corrupt the frame check sequence.

Top module: `txev_irq_mon`

## Requirements
- R1: After reset the register reads 0x0007. Bits 5:0 always read the code 6'b000111, and writes to them are ignored. Bits 14:12 read 0. Bits 15 and 11:6 read back what was written.
- R2: An attempt that ends (`tx_end` while active) with no collision raises `irq` when bit 8 is set.
- R3: When the current packet has seen at least one collision, `irq` is raised at the end of the attempt if bit 11 is set, and not at the collision itself.
- R4: A collision after LATE_BITS bit times of an attempt pulses `force_bad_crc` and `tx_abort`, and raises `irq` if bit 9 is set. An earlier collision does neither.
- R5: The MAX_COLL-th collision within the late window on one packet pulses `tx_abort` and raises `irq` if bit 15 is set. Earlier collisions do not. The count restarts when a new packet starts (`tx_first` with `tx_start`) or when an attempt succeeds.
- R6: `pre_done` while `crs` is low raises `irq` if bit 6 is set. With `crs` high it raises nothing.
- R7: If no collision arrives within SQE_BITS bit times after an attempt ends, `irq` is raised (bit 7 set) on the SQE_BITS-th bit time. A collision inside that window cancels the event.
- R8: An attempt still active JABBER_CYCLES clock cycles after `tx_start` pulses `tx_abort` and raises `irq` if bit 10 is set. The pulse appears exactly JABBER_CYCLES cycles after the start edge.
- R9: An event whose enable bit is clear raises no `irq`. The abort and bad-CRC controls still act.
- R10: Outputs are registered one cycle after the causing input. `irq` is a single-cycle pulse per event, and events that coincide are ORed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| reg_we | input | 1 | Configuration register write strobe |
| reg_wdata | input | 16 | Configuration write data |
| reg_rdata | output | 16 | Live configuration register value |
| tx_start | input | 1 | Start of a transmit attempt |
| tx_first | input | 1 | Qualifies tx_start as first attempt of a new packet |
| pre_done | input | 1 | Preamble finished |
| tx_end | input | 1 | Attempt finished |
| col | input | 1 | Collision detected |
| crs | input | 1 | Carrier sense |
| irq | output | 1 | Interrupt pulse |
| tx_abort | output | 1 | Abandon the current attempt |
| force_bad_crc | output | 1 | Corrupt the frame check sequence |

## Verification
The bench builds the block with LATE_BITS=32, SQE_BITS=8 and JABBER_CYCLES=200, and holds `bit_tick` high every cycle, so that one bit time is one clock. With these values the late-collision boundary, the heartbeat window and the exact cycle of the length-limit abort can all be reached in a few hundred cycles. The default length limit, millions of cycles, would be out of reach. MAX_COLL stays at 16, so the retry limit is exercised at its real value across sixteen attempts.

// File: rtl/txev_pkg.sv
package txev_pkg;
   localparam int unsigned CFG_W = 16;
   localparam logic [5:0]  ID_CODE = 6'b000111;

   // enable / event bit positions within the configuration word
   localparam int unsigned B_NOCRS  = 6;
   localparam int unsigned B_SQE    = 7;
   localparam int unsigned B_OK     = 8;
   localparam int unsigned B_LATE   = 9;
   localparam int unsigned B_JAB    = 10;
   localparam int unsigned B_ANYCOL = 11;
   localparam int unsigned B_MAXCOL = 15;

   localparam logic [CFG_W-1:0] EN_MASK =
      CFG_W'((1 << B_NOCRS) | (1 << B_SQE) | (1 << B_OK) | (1 << B_LATE) |
             (1 << B_JAB) | (1 << B_ANYCOL) | (1 << B_MAXCOL));
endpackage

// File: rtl/txev_cfg_reg.sv
module txev_cfg_reg
   import txev_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] en,
   output logic [CFG_W-1:0] rdata
);
   logic [CFG_W-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= '0;
      else if (we) en_q <= wdata & EN_MASK;
   end

   assign en    = en_q;
   assign rdata = en_q | {{(CFG_W-6){1'b0}}, ID_CODE};
endmodule

// File: rtl/txev_attempt.sv
module txev_attempt #(
   parameter int unsigned LATE_BITS     = 512,
   parameter int unsigned MAX_COLL      = 16,
   parameter int unsigned JABBER_CYCLES = 5_200_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic tx_start,
   input  logic tx_first,
   input  logic pre_done,
   input  logic tx_end,
   input  logic col,
   input  logic crs,
   output logic ev_ok,
   output logic ev_anycol,
   output logic ev_late,
   output logic ev_max,
   output logic ev_jab,
   output logic ev_nocrs,
   output logic attempt_end
);
   localparam int unsigned BW = $clog2(LATE_BITS + 1);
   localparam int unsigned CW = $clog2(MAX_COLL + 1);
   localparam int unsigned JW = $clog2(JABBER_CYCLES + 1);
   localparam logic [BW-1:0] LATE_V  = BW'(LATE_BITS);
   localparam logic [CW-1:0] MAX_V   = CW'(MAX_COLL);
   localparam logic [CW-1:0] LAST_C  = CW'(MAX_COLL - 1);
   localparam logic [JW-1:0] LAST_J  = JW'(JABBER_CYCLES - 1);

   logic          active_q, att_col_q, pkt_col_q;
   logic [BW-1:0] bit_cnt_q;
   logic [CW-1:0] col_cnt_q;
   logic [JW-1:0] jab_cnt_q;
   logic          col_now, col_normal, abort_now;

   assign col_now     = active_q && col;
   assign col_normal  = col_now && (bit_cnt_q < LATE_V);
   assign ev_late     = col_now && (bit_cnt_q >= LATE_V);
   assign ev_max      = col_normal && (col_cnt_q == LAST_C);
   assign ev_jab      = active_q && (jab_cnt_q == LAST_J);
   assign ev_nocrs    = active_q && pre_done && !crs;
   assign attempt_end = active_q && tx_end;
   assign ev_ok       = attempt_end && !att_col_q && !col;
   assign ev_anycol   = attempt_end && (pkt_col_q || col);
   assign abort_now   = ev_late || ev_max || ev_jab;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         att_col_q <= 1'b0;
         pkt_col_q <= 1'b0;
         bit_cnt_q <= '0;
         col_cnt_q <= '0;
         jab_cnt_q <= '0;
      end else if (tx_start) begin
         active_q  <= 1'b1;
         att_col_q <= 1'b0;
         bit_cnt_q <= '0;
         jab_cnt_q <= '0;
         if (tx_first) begin
            col_cnt_q <= '0;
            pkt_col_q <= 1'b0;
         end
      end else if (active_q) begin
         if (attempt_end || abort_now) active_q <= 1'b0;
         if (bit_tick && (bit_cnt_q != LATE_V)) bit_cnt_q <= bit_cnt_q + 1'b1;
         if (jab_cnt_q != LAST_J) jab_cnt_q <= jab_cnt_q + 1'b1;
         if (col) begin
            att_col_q <= 1'b1;
            pkt_col_q <= 1'b1;
         end
         if (ev_ok) begin
            col_cnt_q <= '0;
            pkt_col_q <= 1'b0;
         end else if (col_normal && (col_cnt_q != MAX_V)) begin
            col_cnt_q <= col_cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/txev_sqe_mon.sv
module txev_sqe_mon #(
   parameter bit          ENABLE   = 1'b1,
   parameter int unsigned SQE_BITS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic arm,
   input  logic cancel,
   input  logic col,
   output logic ev_sqe
);
   localparam int unsigned SW = $clog2(SQE_BITS + 1);
   localparam logic [SW-1:0] LAST_S = SW'(SQE_BITS - 1);

   generate
      if (ENABLE) begin : g_sqe
         logic          wait_q;
         logic [SW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wait_q <= 1'b0;
               cnt_q  <= '0;
            end else if (cancel) begin
               wait_q <= 1'b0;
            end else if (arm) begin
               wait_q <= 1'b1;
               cnt_q  <= '0;
            end else if (wait_q) begin
               if (col) begin
                  wait_q <= 1'b0;
               end else if (bit_tick) begin
                  if (cnt_q == LAST_S) wait_q <= 1'b0;
                  else                 cnt_q  <= cnt_q + 1'b1;
               end
            end
         end

         assign ev_sqe = wait_q && !cancel && !arm && !col && bit_tick &&
                         (cnt_q == LAST_S);
      end else begin : g_nosqe
         assign ev_sqe = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/txev_irq_mon.sv
module txev_irq_mon
   import txev_pkg::*;
#(
   parameter int unsigned LATE_BITS     = 512,
   parameter int unsigned MAX_COLL      = 16,
   parameter int unsigned SQE_BITS      = 64,
   parameter int unsigned JABBER_CYCLES = 5_200_000,
   parameter bit          SQE_CHECK     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             reg_we,
   input  logic [CFG_W-1:0] reg_wdata,
   output logic [CFG_W-1:0] reg_rdata,
   input  logic             tx_start,
   input  logic             tx_first,
   input  logic             pre_done,
   input  logic             tx_end,
   input  logic             col,
   input  logic             crs,
   output logic             irq,
   output logic             tx_abort,
   output logic             force_bad_crc
);
   generate
      if (LATE_BITS < 1)     begin : g_chk_late $error("LATE_BITS must be >= 1"); end
      if (MAX_COLL < 2)      begin : g_chk_coll $error("MAX_COLL must be >= 2"); end
      if (SQE_BITS < 1)      begin : g_chk_sqe  $error("SQE_BITS must be >= 1"); end
      if (JABBER_CYCLES < 2) begin : g_chk_jab  $error("JABBER_CYCLES must be >= 2"); end
   endgenerate

   logic [CFG_W-1:0] en;
   logic ev_ok, ev_anycol, ev_late, ev_max, ev_jab, ev_nocrs, ev_sqe, att_end;
   logic [CFG_W-1:0] ev;
   logic irq_q, abort_q, bad_crc_q;

   txev_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
      .en(en), .rdata(reg_rdata)
   );

   txev_attempt #(
      .LATE_BITS(LATE_BITS), .MAX_COLL(MAX_COLL), .JABBER_CYCLES(JABBER_CYCLES)
   ) u_att (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_start(tx_start),
      .tx_first(tx_first), .pre_done(pre_done), .tx_end(tx_end), .col(col),
      .crs(crs), .ev_ok(ev_ok), .ev_anycol(ev_anycol), .ev_late(ev_late),
      .ev_max(ev_max), .ev_jab(ev_jab), .ev_nocrs(ev_nocrs),
      .attempt_end(att_end)
   );

   txev_sqe_mon #(.ENABLE(SQE_CHECK), .SQE_BITS(SQE_BITS)) u_sqe (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .arm(att_end),
      .cancel(tx_start), .col(col), .ev_sqe(ev_sqe)
   );

   always_comb begin
      ev           = '0;
      ev[B_NOCRS]  = ev_nocrs;
      ev[B_SQE]    = ev_sqe;
      ev[B_OK]     = ev_ok;
      ev[B_LATE]   = ev_late;
      ev[B_JAB]    = ev_jab;
      ev[B_ANYCOL] = ev_anycol;
      ev[B_MAXCOL] = ev_max;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q     <= 1'b0;
         abort_q   <= 1'b0;
         bad_crc_q <= 1'b0;
      end else begin
         irq_q     <= |(ev & en);
         abort_q   <= ev_late || ev_max || ev_jab;
         bad_crc_q <= ev_late;
      end
   end

   assign irq           = irq_q;
   assign tx_abort      = abort_q;
   assign force_bad_crc = bad_crc_q;
endmodule

// File: rtl/txev_irq_mon_chk.sv
module txev_irq_mon_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        col,
   input logic [15:0] reg_rdata,
   input logic        irq,
   input logic        tx_abort,
   input logic        force_bad_crc
);
   // R1
   id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[5:0] == 6'b000111) && (reg_rdata[14:12] == 3'b000));

   // R4
   bad_crc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_bad_crc |-> tx_abort);

   // R4
   bad_crc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_bad_crc |-> $past(col));

   // R9
   irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(reg_rdata[15:6]) != 10'd0));

   // R10
   abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> !tx_abort);
endmodule

bind txev_irq_mon txev_irq_mon_chk u_chk (.*);

// File: tb/txev_irq_mon_tb.sv
`timescale 1ns/1ps
module txev_irq_mon_tb;
   localparam int unsigned LB = 32;
   localparam int unsigned SB = 8;
   localparam int unsigned JC = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b1;
   logic reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic tx_start = 0, tx_first = 0, pre_done = 0, tx_end = 0, col = 0, crs = 1;
   logic irq, tx_abort, force_bad_crc;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   txev_irq_mon #(.LATE_BITS(LB), .MAX_COLL(16), .SQE_BITS(SB),
                  .JABBER_CYCLES(JC), .SQE_CHECK(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_start(tx_start),
      .tx_first(tx_first), .pre_done(pre_done), .tx_end(tx_end), .col(col),
      .crs(crs), .irq(irq), .tx_abort(tx_abort), .force_bad_crc(force_bad_crc)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] v);
      reg_we = 1; reg_wdata = v; tick(); reg_we = 0;
   endtask

   task automatic start(input logic first);
      tx_start = 1; tx_first = first; tick(); tx_start = 0; tx_first = 0;
   endtask

   task automatic idle();
      tick(SB + 4);
   endtask

   task automatic t_reset_reg();
      check("R1 reset value", reg_rdata, 16'h0007);
      check("R10 irq low after reset", irq, 0);
      wr(16'hFFFF);
      check("R1 write all ones", reg_rdata, 16'h8FC7);
      wr(16'h0000);
      check("R1 write zero keeps id", reg_rdata, 16'h0007);
   endtask

   task automatic t_ok();
      wr(16'h0100);
      start(1); tick(3);
      check("R2 no irq mid attempt", irq, 0);
      tx_end = 1; tick(); tx_end = 0;
      check("R2 ok irq", irq, 1);
      tick();
      check("R10 irq single pulse", irq, 0);
      idle();
   endtask

   task automatic t_anycol();
      wr(16'h0800);
      start(1); tick(2);
      col = 1; tick(); col = 0;
      check("R3 no irq at collision", irq, 0);
      tick(2);
      tx_end = 1; tick(); tx_end = 0;
      check("R3 any-collision irq at end", irq, 1);
      idle();
   endtask

   task automatic t_late();
      wr(16'h0200);
      start(1); tick(3);
      col = 1; tick(); col = 0;
      check("R4 early col no abort", tx_abort, 0);
      check("R4 early col no bad crc", force_bad_crc, 0);
      check("R4 early col no irq", irq, 0);
      tx_end = 1; tick(); tx_end = 0; idle();
      start(1); tick(LB + 8);
      col = 1; tick(); col = 0;
      check("R4 late col abort", tx_abort, 1);
      check("R4 late col bad crc", force_bad_crc, 1);
      check("R4 late col irq", irq, 1);
      tick();
      check("R10 abort pulse ends", tx_abort, 0);
      idle();
   endtask

   task automatic t_maxcol();
      wr(16'h8000);
      for (int a = 0; a < 16; a++) begin
         start(a == 0); tick();
         col = 1; tick(); col = 0;
         if (a < 15) begin
            if (tx_abort !== 1'b0 || irq !== 1'b0)
               check("R5 early collision no abort", {tx_abort, irq}, 2'b00);
            tx_end = 1; tick(); tx_end = 0; tick(2);
         end else begin
            check("R5 16th collision abort", tx_abort, 1);
            check("R5 16th collision irq", irq, 1);
         end
      end
      idle();
      start(1); tick();
      col = 1; tick(); col = 0;
      check("R5 count restarts on new packet", tx_abort, 0);
      tx_end = 1; tick(); tx_end = 0; idle();
   endtask

   task automatic t_nocrs();
      wr(16'h0040);
      start(1); tick();
      crs = 1; pre_done = 1; tick(); pre_done = 0;
      check("R6 carrier present no irq", irq, 0);
      crs = 0; pre_done = 1; tick(); pre_done = 0; crs = 1;
      check("R6 carrier missing irq", irq, 1);
      tx_end = 1; tick(); tx_end = 0; idle();
   endtask

   task automatic t_sqe();
      logic seen;
      wr(16'h0080);
      start(1); tick(2);
      tx_end = 1; tick(); tx_end = 0;
      tick(SB - 1);
      check("R7 no irq before window ends", irq, 0);
      tick();
      check("R7 sqe missing irq", irq, 1);
      idle();
      start(1); tick(2);
      tx_end = 1; tick(); tx_end = 0;
      tick(3);
      col = 1; tick(); col = 0;
      seen = 0;
      for (int k = 0; k < SB + 2; k++) begin
         tick();
         if (irq) seen = 1;
      end
      check("R7 heartbeat seen no irq", seen, 0);
   endtask

   task automatic t_jabber();
      wr(16'h0400);
      start(1);
      tick(JC - 1);
      check("R8 no jabber before limit", irq, 0);
      tick();
      check("R8 jabber irq", irq, 1);
      check("R8 jabber abort", tx_abort, 1);
      idle();
   endtask

   task automatic t_disabled();
      wr(16'h0000);
      start(1); tick(LB + 4);
      col = 1; tick(); col = 0;
      check("R9 disabled no irq", irq, 0);
      check("R9 abort still acts", tx_abort, 1);
      idle();
   endtask

   initial begin
      tick(3);
      rst_n = 1;
      tick();
      t_reset_reg();
      t_ok();
      t_anycol();
      t_late();
      t_maxcol();
      t_nocrs();
      t_sqe();
      t_jabber();
      t_disabled();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule